// File: doc/BRIEF.md
# Full-Duplex Serial Byte Transceiver (Master/Slave)

This block is a register-controlled synchronous serial port. It swaps one byte with a partner device on each transfer. The same core runs as the clock-generating master or as a selected slave. While the local byte shifts out, the partner's byte shifts in on the same clock edges, so when the transfer ends the data register holds the received byte. A CPU-side port gives access to three registers: control, status and data.

In master mode, a write to the data register starts a one-shot serial clock. The clock runs for exactly eight cycles at one of four rates derived from the system clock, then stops. In slave mode the serial clock, the input data and the active-low select come from outside. They are resynchronised into the system clock domain before their edges are detected. Both modes use the same edge rule: the clock idles low, the receiver samples on the rising edge and the next outgoing bit is placed on the falling edge. A completion flag, with an optional interrupt, marks the end of each byte. A collision flag records a data write that arrives while a transfer is running.

Register map (addr): 0 = control, 1 = status, 2 = data. Control bits: 7 = interrupt enable, 6 = block enable, 5 = LSB-first, 4 = master, 1:0 = rate. Status bits: 7 = transfer done, 6 = write collision.

Top module: `spi_byte_xcvr`

## Requirements
- R1: After reset the control, status and data registers read 0, irq is low and none of sckOe, mosiOe, misoOe is asserted.
- R2: With control bits 6 and 4 set, a data-register write starts a transfer. sckOut idles low and gives exactly eight pulses, then stops low. mosiOut carries the written byte, with each bit stable across the rising edge of sckOut.
- R3: The rate field in control bits 1:0 selects the divisor N: 00 gives 4, 01 gives 16, 10 gives 64 and 11 gives 128. The done flag reads set exactly 8*N clock cycles after the edge that takes the data write.
- R4: After a transfer the data register holds the byte received on misoIn (master) or mosiIn (slave).
- R5: Control bit 5 = 1 sends and receives least significant bit first. Bit 5 = 0 sends and receives most significant bit first.
- R6: Status bit 7 is set at the end of each transfer. irq is high when status bit 7 and control bit 7 are both 1, and low otherwise.
- R7: A data write during a transfer sets status bit 6. The bytes that this transfer sends and receives are unchanged.
- R8: The done and collision flags clear on a data-register access (read or write) that follows a status read made while a flag was set. A data access with no such status read leaves them set.
- R9: In slave mode (bit 6 = 1, bit 4 = 0), sckIn edges are ignored while ssN is high, and misoOut is driven (misoOe = 1) only while ssN is low. While ssN is low, eight sckIn pulses swap the data register with the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (drives the flag-clear sequence) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from a master (slave mode) |
| sckOut | output | 1 | Generated serial clock (master mode) |
| sckOe | output | 1 | Drive enable for sckOut |
| mosiIn | input | 1 | Serial data from a master (slave mode) |
| mosiOut | output | 1 | Serial data to a slave (master mode) |
| mosiOe | output | 1 | Drive enable for mosiOut |
| misoIn | input | 1 | Serial data from a slave (master mode) |
| misoOut | output | 1 | Serial data to a master (slave mode) |
| misoOe | output | 1 | Drive enable for misoOut |
| ssN | input | 1 | Active-low slave select |

## Verification
The hardest state to reach is a data write that lands mid-byte. Reaching it needs a transfer already in flight at a known rate, and the bench then has to show that both shifted bytes are still intact. The bench models the remote slave itself, clocked from sckOut. It starts a transfer at the /16 rate, writes a conflicting byte forty cycles later, and compares both sides of the exchange against the original bytes. For the slave direction, the bench drives sckIn slowly enough to cover the resynchroniser delay. It first toggles sckIn with ssN high to show those edges change nothing.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam int HALF_MAX = 64;
  localparam int DIV_W = $clog2(HALF_MAX);

  // Strobes and serial input handed from control to datapath.
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic lsbFirst;
    logic serIn;
  } dpStrobe_t;

  // Half of the SCK period in system clocks for each rate code.
  function automatic int halfCycles(input logic [1:0] rate);
    case (rate)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return HALF_MAX;
    endcase
  endfunction
endpackage

// File: rtl/spi_xcvr_dp.sv
module spi_xcvr_dp
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] shReg,
  output logic              serialOut
);
  logic smpBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      smpBit <= 1'b0;
    end else begin
      if (strobe.sample) smpBit <= strobe.serIn;
      if (strobe.load) begin
        shReg <= loadData;
      end else if (strobe.shift) begin
        if (strobe.lsbFirst) shReg <= {smpBit, shReg[DATA_W-1:1]};
        else                 shReg <= {shReg[DATA_W-2:0], smpBit};
      end
    end
  end

  assign serialOut = strobe.lsbFirst ? shReg[0] : shReg[DATA_W-1];

  // R7: the byte in flight moves only when a load or shift strobe says so
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> $stable(shReg));
endmodule

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  output logic [DATA_W-1:0] ctrlByte,
  output logic [DATA_W-1:0] statusByte,
  output dpStrobe_t         strobe,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(8'hF3);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] ctrlR;
  logic [SYNC_STAGES-1:0] sckSync, mosiSync, ssSync;
  logic sckPrev;
  logic busyR, sckR, doneR, collR, statusSeen;
  logic [DIV_W-1:0] divCnt, halfLast;
  logic [CNT_W-1:0] bitCnt;

  logic irqEn, enBit, lsbBit, mstBit;
  logic sckS, mosiS, ssS;
  logic mstActive, slvSel, dataWr, dataRd, statRd;
  logic startXfer, collide, mTick, sRise, sFall, lastBit, doneSet, clearFlags;

  assign irqEn  = ctrlR[7];
  assign enBit  = ctrlR[6];
  assign lsbBit = ctrlR[5];
  assign mstBit = ctrlR[4];
  assign halfLast = DIV_W'(halfCycles(ctrlR[1:0]) - 1);

  assign sckS  = sckSync[SYNC_STAGES-1];
  assign mosiS = mosiSync[SYNC_STAGES-1];
  assign ssS   = ssSync[SYNC_STAGES-1];

  assign mstActive = enBit && mstBit;
  assign slvSel    = enBit && !mstBit && !ssS;
  assign dataWr    = wrEn && (addr == ADDR_DATA);
  assign dataRd    = rdEn && (addr == ADDR_DATA);
  assign statRd    = rdEn && (addr == ADDR_STAT);
  assign startXfer = dataWr && mstActive && !busyR;
  assign collide   = dataWr && busyR;
  assign lastBit   = (bitCnt == LAST_BIT);
  assign mTick     = mstActive && busyR && (divCnt == halfLast);
  assign sRise     = slvSel && sckS && !sckPrev;
  assign sFall     = slvSel && !sckS && sckPrev;
  assign doneSet   = (mTick && sckR && lastBit) || (sFall && lastBit);
  assign clearFlags = (dataWr || dataRd) && statusSeen;

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlR <= '0;
    else if (wrEn && addr == ADDR_CTRL) ctrlR <= wrData & CTRL_MASK;
  end

  // Input resynchronisers for the slave-side pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      ssSync   <= '1;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      ssSync   <= {ssSync[SYNC_STAGES-2:0], ssN};
      sckPrev  <= sckS;
    end
  end

  // Transfer sequencing: clock divider, SCK, bit counter, busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR <= 1'b0; sckR <= 1'b0; divCnt <= '0; bitCnt <= '0;
    end else if (!enBit) begin
      busyR <= 1'b0; sckR <= 1'b0; divCnt <= '0; bitCnt <= '0;
    end else if (mstBit) begin
      if (startXfer) begin
        busyR <= 1'b1; sckR <= 1'b0; divCnt <= '0; bitCnt <= '0;
      end else if (busyR) begin
        if (mTick) begin
          divCnt <= '0;
          sckR   <= ~sckR;
          if (sckR) begin
            bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
            if (lastBit) busyR <= 1'b0;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end else begin
      sckR <= 1'b0; divCnt <= '0;
      if (ssS) begin
        busyR <= 1'b0; bitCnt <= '0;
      end else begin
        if (sRise) busyR <= 1'b1;
        if (sFall) begin
          bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
          if (lastBit) busyR <= 1'b0;
        end
      end
    end
  end

  // Flags and the status-then-data clear sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneR <= 1'b0; collR <= 1'b0; statusSeen <= 1'b0;
    end else begin
      if (doneSet) doneR <= 1'b1;
      else if (clearFlags) doneR <= 1'b0;
      if (collide) collR <= 1'b1;
      else if (clearFlags) collR <= 1'b0;
      if (statRd && (doneR || collR)) statusSeen <= 1'b1;
      else if (dataWr || dataRd) statusSeen <= 1'b0;
    end
  end

  always_comb begin
    strobe.load     = dataWr && !busyR;
    strobe.sample   = (mTick && !sckR) || sRise;
    strobe.shift    = (mTick && sckR) || sFall;
    strobe.lsbFirst = lsbBit;
    strobe.serIn    = mstBit ? misoIn : mosiS;
  end

  assign ctrlByte   = ctrlR;
  assign statusByte = {doneR, collR, {(DATA_W-2){1'b0}}};
  assign sckOut     = sckR;
  assign sckOe      = mstActive;
  assign mosiOe     = mstActive;
  assign misoOe     = slvSel;
  assign irq        = irqEn && doneR;

  // R2: the generated clock rests low whenever no master transfer runs
  assert_sck_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mstActive && !busyR) |-> !sckR);
  // R6: completion appears only at the end of a running transfer
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneR) |-> $past(busyR));
  // R8: the done flag drops only through the clear sequence
  assert_flag_clear_seq_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneR) |-> $past(clearFlags));
  // R9: deselecting a slave abandons any partial byte
  assert_bitcnt_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!mstActive && !slvSel) |=> (bitCnt == '0));
endmodule

// File: rtl/spi_byte_xcvr.sv
module spi_byte_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  dpStrobe_t strobe;
  logic [DATA_W-1:0] ctrlByte, statusByte, shReg;
  logic serialOut;

  spi_xcvr_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .ssN(ssN), .ctrlByte(ctrlByte), .statusByte(statusByte),
    .strobe(strobe), .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe),
    .misoOe(misoOe), .irq(irq)
  );

  spi_xcvr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(wrData),
    .shReg(shReg), .serialOut(serialOut)
  );

  assign mosiOut = serialOut;
  assign misoOut = serialOut;

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = ctrlByte;
      ADDR_STAT: rdData = statusByte;
      ADDR_DATA: rdData = shReg;
      default:   rdData = '0;
    endcase
  end

  // R9: never drive as master and slave at once
  assert_single_role_R9: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !sckOe);
endmodule

// File: tb/spi_byte_xcvr_tb.sv
module spi_byte_xcvr_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic irq, sckIn = 1'b0, sckOut, sckOe, mosiIn = 1'b0, mosiOut, mosiOe;
  logic misoIn, misoOut, misoOe, ssN = 1'b1;

  int nChk = 0, nErr = 0;
  bit finished = 0;

  // Remote slave model used in master tests
  logic [7:0] bsTx = '0, bsRx = '0;
  logic bsLsb = 1'b0;

  spi_byte_xcvr u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .ssN(ssN)
  );

  always #5 clk = ~clk;

  assign misoIn = bsLsb ? bsTx[0] : bsTx[7];
  always @(posedge sckOut) bsRx = bsLsb ? {mosiOut, bsRx[7:1]} : {bsRx[6:0], mosiOut};
  always @(negedge sckOut) bsTx = bsLsb ? (bsTx >> 1) : (bsTx << 1);

  // {rate[1:0], lsbFirst, masterByte, slaveByte}
  localparam logic [18:0] VEC [0:5] = '{
    {2'd0, 1'b0, 8'hA5, 8'h3C},
    {2'd1, 1'b1, 8'h81, 8'h7E},
    {2'd2, 1'b0, 8'h00, 8'hFF},
    {2'd3, 1'b1, 8'hC3, 8'h5A},
    {2'd0, 1'b1, 8'h01, 8'h80},
    {2'd1, 1'b0, 8'hFE, 8'h11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  function automatic int divisor(input logic [1:0] r);
    case (r)
      2'd0: return 4;
      2'd1: return 16;
      2'd2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic waitDone(output int cyc);
    cyc = 0;
    addr = 2'd1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rdData[7] && cyc < 5000);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v, cap;
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
    peek(2'd1, v); chk("R1 status", v, 8'h00);
    peek(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 pins", {irq, sckOe, mosiOe, misoOe}, 4'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pins after release", {irq, sckOe, mosiOe, misoOe}, 4'b0);

    // Table walk: R2 R3 R4 R5 R6 R8
    foreach (VEC[i]) begin
      logic [1:0] rate; logic lsb; logic [7:0] mB, sB;
      {rate, lsb, mB, sB} = VEC[i];
      wr(2'd0, {1'b1, 1'b1, lsb, 1'b1, 2'b00, rate});
      bsLsb = lsb; bsTx = sB; bsRx = '0;
      chk("R2 sck idle", sckOut, 1'b0);
      wr(2'd2, mB);
      waitDone(cyc);
      chk("R3 cycles", cyc, 8 * divisor(rate));
      chk("R2 R5 mosi byte", bsRx, mB);
      chk("R2 sck stopped low", sckOut, 1'b0);
      peek(2'd2, v); chk("R4 R5 received", v, sB);
      chk("R6 irq", irq, 1'b1);
      rd(2'd1); rd(2'd2);
      peek(2'd1, v); chk("R8 cleared", v, 8'h00);
    end

    // R6 irq disabled; R8 data access without status read
    wr(2'd0, 8'h50);
    bsLsb = 1'b0; bsTx = 8'h42;
    wr(2'd2, 8'h24);
    waitDone(cyc);
    chk("R6 irq masked", irq, 1'b0);
    rd(2'd2);
    peek(2'd1, v); chk("R8 no clear without status read", v, 8'h80);
    rd(2'd1); rd(2'd2);
    peek(2'd1, v); chk("R8 cleared after sequence", v, 8'h00);

    // R7 collision mid-transfer at /16
    wr(2'd0, 8'h51);
    bsTx = 8'h69; bsRx = '0;
    wr(2'd2, 8'h96);
    repeat (40) @(negedge clk);
    wr(2'd2, 8'h00);
    peek(2'd1, v); chk("R7 collision flag", v[6], 1'b1);
    waitDone(cyc);
    chk("R7 sent byte intact", bsRx, 8'h96);
    peek(2'd2, v); chk("R7 received byte intact", v, 8'h69);
    rd(2'd1); rd(2'd2);
    peek(2'd1, v); chk("R8 collision cleared", v, 8'h00);

    // R9 slave mode, MSB first
    wr(2'd0, 8'h40);
    wr(2'd2, 8'hB4);
    repeat (4) @(negedge clk);
    chk("R9 miso off when deselected", misoOe, 1'b0);
    for (int b = 0; b < 8; b++) begin
      repeat (6) @(negedge clk); sckIn = 1'b1;
      repeat (6) @(negedge clk); sckIn = 1'b0;
    end
    repeat (8) @(negedge clk);
    peek(2'd1, v); chk("R9 ignored status", v, 8'h00);
    peek(2'd2, v); chk("R9 ignored data", v, 8'hB4);
    ssN = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 miso driven when selected", misoOe, 1'b1);
    cap = '0;
    for (int b = 7; b >= 0; b--) begin
      mosiIn = 8'h2D >> b;
      repeat (6) @(negedge clk);
      cap = {cap[6:0], misoOut};
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R9 slave sent", cap, 8'hB4);
    peek(2'd2, v); chk("R9 R4 slave received", v, 8'h2D);
    peek(2'd1, v); chk("R9 R6 slave done", v, 8'h80);
    ssN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 miso released", misoOe, 1'b0);

    summary();
  end
endmodule